// File: doc/BRIEF.md
# Transaction write-set tracker

This block gives one hardware thread best-effort transactional memory. It keeps speculative stores locally and checks for conflicts only against the lines the transaction has touched. A start command opens a transaction and latches the address that the core must jump to if the transaction fails. While the transaction runs, the block records each cache line that is read in a read set. Each line that is stored to goes into a bounded write log together with its newest data. Memory sees none of this speculative data until commit.

On commit, the logged lines go to a memory write port one line at a time, in the order the lines were first stored. Each line waits for a memory acknowledge. Many things abort the transaction: a coherence invalidation that hits a tracked line, running out of log or read-set room, an event reported by the core, or an explicit abort. An abort discards every speculative entry and latches a cause vector. It then pulses a redirect carrying the latched fail address. After that the block stays idle until software starts a new transaction. Retry and contention policy are left to software.

Top module: `tm_wset_tracker`

## Requirements
- R1: After reset the block is idle: active_o, busy_o, mem_wr_o and redirect_o are 0, and status_o is 0.
- R2: start_i while idle makes active_o 1 from the next cycle and clears status_o to 0. start_i while a transaction is active or a drain is running is ignored: the fail address stays as first latched, and no new transaction begins after a drain.
- R3: No memory write is issued while a transaction is active. Stores stay local until commit.
- R4: Commit with logged lines raises busy_o and mem_wr_o from the next cycle. Each logged line is presented, with its latest stored data, in first-store order, and each is held stable until mem_ack_i. Repeated stores to one line give one write. The drain ends after the ack of the last line. A commit with no stores returns to idle on the next cycle with no write.
- R5: An abort discards the write log and the read set. A later transaction writes back only its own lines.
- R6: An invalidation whose line is in the read set or the write log aborts with status bit 0 (conflict). An invalidation of an untracked line has no effect.
- R7: A store to a new line with LOG_DEPTH lines logged, or a read of a new line with RD_DEPTH lines in the read set, aborts with status bit 1 (capacity). A store to an already logged line when the log is full does not abort.
- R8: Core events abort with one status bit each: bit 2 for interrupt or exception, bit 3 for translation miss, bit 4 for branch mispredict, and bit 5 for explicit abort.
- R9: An abort makes redirect_o 1 for exactly one cycle, starting the cycle after the abort, with redirect_pc_o equal to the latched fail address. active_o is 0 from then on, and the block stays idle with no automatic restart.
- R10: Invalidations and start_i that arrive during a drain are ignored. Every logged line is still written.
- R11: An abort cause in the same cycle as commit_i wins. The transaction aborts and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transaction |
| fail_pc_i | input | PC_W | Fail address latched at start |
| commit_i | input | 1 | Commit the active transaction |
| abort_i | input | 1 | Explicit abort request |
| rd_i | input | 1 | Transactional load |
| rd_line_i | input | ADDR_W | Line address of the load |
| wr_i | input | 1 | Transactional store |
| wr_line_i | input | ADDR_W | Line address of the store |
| wr_data_i | input | DATA_W | Store data |
| inv_i | input | 1 | Coherence invalidation |
| inv_line_i | input | ADDR_W | Invalidated line address |
| evt_irq_i | input | 1 | Interrupt during transaction |
| evt_exc_i | input | 1 | Exception during transaction |
| evt_tlb_i | input | 1 | Translation miss during transaction |
| evt_bmis_i | input | 1 | Branch mispredict during transaction |
| active_o | output | 1 | Transaction running |
| busy_o | output | 1 | Commit drain running |
| status_o | output | 6 | Abort cause bits of the last transaction |
| redirect_o | output | 1 | One-cycle redirect pulse after abort |
| redirect_pc_o | output | PC_W | Redirect target (latched fail address) |
| mem_wr_o | output | 1 | Memory write request |
| mem_line_o | output | ADDR_W | Line being written |
| mem_data_o | output | DATA_W | Data being written |
| mem_ack_i | input | 1 | Memory accepted the current line |

## Verification
Every stimulus is registered once: active_o, status_o, redirect_o and the first memory write all change on the cycle after the input cycle. The bench therefore drives each input on a falling edge and reads the result on the next falling edge. During a drain, each acknowledge moves the port to the next line one cycle later. The bench checks one line per cycle and inserts a stall, in which the line must stay put, to exercise the hold. Ignored stimuli are judged one cycle later through active_o, redirect_pc_o, or the complete sequence of written lines.

// File: rtl/tm_pkg.sv
package tm_pkg;
   localparam int CAUSE_W    = 6;
   localparam int C_CONFLICT = 0;
   localparam int C_CAPACITY = 1;
   localparam int C_INTEXC   = 2;
   localparam int C_TLB      = 3;
   localparam int C_BMIS     = 4;
   localparam int C_EXPLICIT = 5;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_DRAIN  = 2'd2
   } tm_state_e;
endpackage

// File: rtl/tm_linetab.sv
// Associative line table with allocation-order storage. Used both as the
// write log (with data) and as the read set (tags only).
module tm_linetab #(
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter bit KEEP_DATA = 1'b1,
   localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              add_i,
   input  logic [ADDR_W-1:0] add_line_i,
   input  logic [DATA_W-1:0] add_data_i,
   input  logic [ADDR_W-1:0] probe_line_i,
   output logic              probe_hit_o,
   output logic              full_miss_o,
   output logic [CNT_W-1:0]  count_o,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_line_o,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DEPTH-1:0]  vld_q;
   logic [DEPTH-1:0]  add_match;
   logic [DEPTH-1:0]  probe_match;
   logic [ADDR_W-1:0] line_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              add_hit;
   logic              is_full;
   logic              alloc;
   logic [IDX_W-1:0]  wr_idx;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign add_match[i]   = vld_q[i] && (line_q[i] == add_line_i);
      assign probe_match[i] = vld_q[i] && (line_q[i] == probe_line_i);
   end

   assign add_hit     = |add_match;
   assign is_full     = (cnt_q == CNT_W'(DEPTH));
   assign full_miss_o = add_i && !add_hit && is_full;
   assign probe_hit_o = |probe_match;
   assign count_o     = cnt_q;
   assign alloc       = add_i && !add_hit && !is_full && !clr_i;
   assign wr_idx      = cnt_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         vld_q <= '0;
         cnt_q <= '0;
      end else if (alloc) begin
         vld_q[wr_idx] <= 1'b1;
         cnt_q         <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc) line_q[wr_idx] <= add_line_i;
   end

   assign rd_line_o = line_q[rd_idx_i];

   if (KEEP_DATA) begin : g_data
      logic [DATA_W-1:0] data_q [DEPTH];
      always_ff @(posedge clk) begin
         if (alloc) data_q[wr_idx] <= add_data_i;
         for (int i = 0; i < DEPTH; i++) begin
            if (add_i && !clr_i && add_match[i]) data_q[i] <= add_data_i;
         end
      end
      assign rd_data_o = data_q[rd_idx_i];
   end else begin : g_tags_only
      assign rd_data_o = '0;
   end
endmodule

// File: rtl/tm_wset_tracker.sv
module tm_wset_tracker
   import tm_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int PC_W      = 16,
   parameter int LOG_DEPTH = 16,
   parameter int RD_DEPTH  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PC_W-1:0]    fail_pc_i,
   input  logic               commit_i,
   input  logic               abort_i,
   input  logic               rd_i,
   input  logic [ADDR_W-1:0]  rd_line_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  wr_line_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic               inv_i,
   input  logic [ADDR_W-1:0]  inv_line_i,
   input  logic               evt_irq_i,
   input  logic               evt_exc_i,
   input  logic               evt_tlb_i,
   input  logic               evt_bmis_i,
   output logic               active_o,
   output logic               busy_o,
   output logic [CAUSE_W-1:0] status_o,
   output logic               redirect_o,
   output logic [PC_W-1:0]    redirect_pc_o,
   output logic               mem_wr_o,
   output logic [ADDR_W-1:0]  mem_line_o,
   output logic [DATA_W-1:0]  mem_data_o,
   input  logic               mem_ack_i
);
   localparam int LIDX_W = $clog2(LOG_DEPTH);
   localparam int LCNT_W = $clog2(LOG_DEPTH + 1);
   localparam int RIDX_W = (RD_DEPTH > 1) ? $clog2(RD_DEPTH) : 1;
   localparam int RCNT_W = $clog2(RD_DEPTH + 1);

   if (!(LOG_DEPTH == 16 || LOG_DEPTH == 32)) begin : g_bad_log_depth
      $error("tm_wset_tracker: LOG_DEPTH must be 16 or 32");
   end
   if (RD_DEPTH < 2) begin : g_bad_rd_depth
      $error("tm_wset_tracker: RD_DEPTH must be at least 2");
   end

   tm_state_e          st_q;
   logic [LIDX_W-1:0]  drain_q;
   logic [CAUSE_W-1:0] status_q;
   logic [CAUSE_W-1:0] cause;
   logic [PC_W-1:0]    fail_pc_q;
   logic               redirect_q;
   logic               in_tx;
   logic               abort_go;
   logic               start_go;
   logic               clr_tabs;
   logic               drain_last;

   logic               wl_hit, wl_full_miss;
   logic [LCNT_W-1:0]  wl_cnt;
   logic               rs_hit, rs_full_miss;
   logic [RCNT_W-1:0]  rs_cnt;
   logic [ADDR_W-1:0]  rs_line_nc;
   logic [0:0]         rs_data_nc;

   assign in_tx    = (st_q == ST_ACTIVE);
   assign start_go = (st_q == ST_IDLE) && start_i;

   always_comb begin
      cause             = '0;
      cause[C_CONFLICT] = inv_i && (wl_hit || rs_hit);
      cause[C_CAPACITY] = wl_full_miss || rs_full_miss;
      cause[C_INTEXC]   = evt_irq_i || evt_exc_i;
      cause[C_TLB]      = evt_tlb_i;
      cause[C_BMIS]     = evt_bmis_i;
      cause[C_EXPLICIT] = abort_i;
      if (!in_tx) cause = '0;
   end

   assign abort_go = |cause;
   assign clr_tabs = start_go || abort_go;

   tm_linetab #(
      .DEPTH(LOG_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_DATA(1'b1)
   ) u_wlog (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_tabs),
      .add_i(in_tx && wr_i), .add_line_i(wr_line_i), .add_data_i(wr_data_i),
      .probe_line_i(inv_line_i), .probe_hit_o(wl_hit),
      .full_miss_o(wl_full_miss), .count_o(wl_cnt),
      .rd_idx_i(drain_q), .rd_line_o(mem_line_o), .rd_data_o(mem_data_o)
   );

   tm_linetab #(
      .DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .DATA_W(1), .KEEP_DATA(1'b0)
   ) u_rset (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_tabs),
      .add_i(in_tx && rd_i), .add_line_i(rd_line_i), .add_data_i(1'b0),
      .probe_line_i(inv_line_i), .probe_hit_o(rs_hit),
      .full_miss_o(rs_full_miss), .count_o(rs_cnt),
      .rd_idx_i(RIDX_W'(0)), .rd_line_o(rs_line_nc), .rd_data_o(rs_data_nc)
   );

   assign drain_last = ((LCNT_W'(drain_q) + 1'b1) == wl_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         drain_q    <= '0;
         status_q   <= '0;
         fail_pc_q  <= '0;
         redirect_q <= 1'b0;
      end else begin
         redirect_q <= abort_go;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q      <= ST_ACTIVE;
                  status_q  <= '0;
                  fail_pc_q <= fail_pc_i;
               end
            end
            ST_ACTIVE: begin
               if (abort_go) begin
                  st_q     <= ST_IDLE;
                  status_q <= cause;
               end else if (commit_i) begin
                  drain_q <= '0;
                  st_q    <= (wl_cnt == '0 && !wr_i) ? ST_IDLE : ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (mem_ack_i) begin
                  if (drain_last) st_q <= ST_IDLE;
                  else            drain_q <= drain_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign active_o      = in_tx;
   assign busy_o        = (st_q == ST_DRAIN);
   assign mem_wr_o      = (st_q == ST_DRAIN);
   assign status_o      = status_q;
   assign redirect_o    = redirect_q;
   assign redirect_pc_o = fail_pc_q;
endmodule

// File: rtl/tm_wset_tracker_chk.sv
module tm_wset_tracker_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              commit_i,
   input logic              mem_ack_i,
   input logic              active_o,
   input logic              busy_o,
   input logic [5:0]        status_o,
   input logic              redirect_o,
   input logic              mem_wr_o,
   input logic [ADDR_W-1:0] mem_line_o,
   input logic [DATA_W-1:0] mem_data_o
);
   p_write_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_o) |-> ($past(active_o) && $past(commit_i)));

   p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !mem_ack_i) |=> (mem_wr_o && $stable(mem_line_o) && $stable(mem_data_o)));

   p_status_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_o) |-> (status_o == 6'd0));

   p_no_start_in_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !active_o);

   p_redirect_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o);

   p_redirect_from_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> ($past(active_o) && !active_o && !busy_o && (status_o != 6'd0)));

   p_drain_not_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mem_ack_i) |=> (busy_o && !redirect_o));
endmodule

bind tm_wset_tracker tm_wset_tracker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tm_wset_tracker_tb_top.sv
module tm_wset_tracker_tb_top;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int PC_W   = 16;
   localparam int LOGD   = 16;
   localparam int RDD    = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 0, commit_i = 0, abort_i = 0, rd_i = 0, wr_i = 0, inv_i = 0;
   logic [PC_W-1:0]   fail_pc_i = '0;
   logic [ADDR_W-1:0] rd_line_i = '0, wr_line_i = '0, inv_line_i = '0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic              evt_irq_i = 0, evt_exc_i = 0, evt_tlb_i = 0, evt_bmis_i = 0;
   logic              mem_ack_i = 0;
   logic              active_o, busy_o, redirect_o, mem_wr_o;
   logic [5:0]        status_o;
   logic [PC_W-1:0]   redirect_pc_o;
   logic [ADDR_W-1:0] mem_line_o;
   logic [DATA_W-1:0] mem_data_o;

   int total = 0;
   int bad = 0;
   logic [ADDR_W-1:0] exp_line [32];
   logic [DATA_W-1:0] exp_data [32];

   always #5 clk = ~clk;

   tm_wset_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W),
                     .LOG_DEPTH(LOGD), .RD_DEPTH(RDD)) dut_i (.*);

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic begin_tx(logic [PC_W-1:0] pc);
      start_i = 1; fail_pc_i = pc; step(); start_i = 0;
      chk("R2 active after start", active_o, 1);
      chk("R2 status cleared", status_o, 0);
   endtask

   task automatic store(logic [ADDR_W-1:0] l, logic [DATA_W-1:0] d);
      wr_i = 1; wr_line_i = l; wr_data_i = d; step(); wr_i = 0;
   endtask

   task automatic load(logic [ADDR_W-1:0] l);
      rd_i = 1; rd_line_i = l; step(); rd_i = 0;
   endtask

   task automatic snoop(logic [ADDR_W-1:0] l);
      inv_i = 1; inv_line_i = l; step(); inv_i = 0;
   endtask

   task automatic expect_abort(string req, logic [5:0] st, logic [PC_W-1:0] pc);
      chk({req, " active low"}, active_o, 0);
      chk({req, " status"}, status_o, st);
      chk("R9 redirect pulse", redirect_o, 1);
      chk("R9 redirect pc", redirect_pc_o, pc);
      chk("R5 no write on abort", mem_wr_o, 0);
      step();
      chk("R9 redirect one cycle", redirect_o, 0);
      chk("R9 stays idle", active_o | busy_o, 0);
   endtask

   task automatic commit_drain(int n, bit disturb);
      commit_i = 1; step(); commit_i = 0;
      for (int k = 0; k < n; k++) begin
         chk("R4 busy in drain", busy_o, 1);
         chk("R4 write request", mem_wr_o, 1);
         chk("R4 line order", mem_line_o, exp_line[k]);
         chk("R4 line data", mem_data_o, exp_data[k]);
         if (k == 0) begin
            if (disturb) begin
               inv_i = 1; inv_line_i = exp_line[0]; start_i = 1; fail_pc_i = 16'hdead;
            end
            step();
            inv_i = 0; start_i = 0;
            chk("R10 drain survives", busy_o, 1);
            chk("R4 hold line", mem_line_o, exp_line[0]);
         end
         mem_ack_i = 1; step(); mem_ack_i = 0;
      end
      chk("R4 drain done", busy_o | mem_wr_o, 0);
      chk("R2 no start after drain", active_o, 0);
   endtask

   task automatic t_reset();
      chk("R1 active", active_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 mem_wr", mem_wr_o, 0);
      chk("R1 redirect", redirect_o, 0);
      chk("R1 status", status_o, 0);
   endtask

   task automatic t_commit_basic();
      begin_tx(16'h0100);
      store(16'h0010, 32'h1111);
      store(16'h0020, 32'h2222);
      store(16'h0010, 32'h3333);
      chk("R3 no write while active", mem_wr_o, 0);
      exp_line[0] = 16'h0010; exp_data[0] = 32'h3333;
      exp_line[1] = 16'h0020; exp_data[1] = 32'h2222;
      commit_drain(2, 0);
      chk("R4 status after commit", status_o, 0);
   endtask

   task automatic t_commit_empty();
      begin_tx(16'h0110);
      commit_i = 1; step(); commit_i = 0;
      chk("R4 empty commit idle", active_o | busy_o | mem_wr_o, 0);
   endtask

   task automatic t_conflict_read();
      begin_tx(16'h0200);
      store(16'h0050, 32'h5555);
      load(16'h0030);
      snoop(16'h0031);
      chk("R6 untracked inv ignored", active_o, 1);
      snoop(16'h0030);
      expect_abort("R6 read conflict", 6'b000001, 16'h0200);
      begin_tx(16'h0210);
      store(16'h0040, 32'h4444);
      exp_line[0] = 16'h0040; exp_data[0] = 32'h4444;
      commit_drain(1, 0);
   endtask

   task automatic t_conflict_write();
      begin_tx(16'h0300);
      store(16'h0060, 32'h6666);
      snoop(16'h0060);
      expect_abort("R6 write conflict", 6'b000001, 16'h0300);
   endtask

   task automatic t_capacity_write();
      begin_tx(16'h0400);
      for (int k = 0; k < LOGD; k++) store(16'h0100 + 16'(k), 32'(k));
      store(16'h0100, 32'h9);
      chk("R7 hit when full no abort", active_o, 1);
      store(16'h0fff, 32'h1);
      expect_abort("R7 write overflow", 6'b000010, 16'h0400);
   endtask

   task automatic t_capacity_read();
      begin_tx(16'h0500);
      for (int k = 0; k < RDD; k++) load(16'h0200 + 16'(k));
      load(16'h0200);
      chk("R7 read hit when full", active_o, 1);
      load(16'h0eee);
      expect_abort("R7 read overflow", 6'b000010, 16'h0500);
   endtask

   task automatic t_events();
      for (int k = 0; k < 5; k++) begin
         begin_tx(16'h0600 + 16'(k));
         case (k)
            0: evt_irq_i = 1;
            1: evt_exc_i = 1;
            2: evt_tlb_i = 1;
            3: evt_bmis_i = 1;
            default: abort_i = 1;
         endcase
         step();
         evt_irq_i = 0; evt_exc_i = 0; evt_tlb_i = 0; evt_bmis_i = 0; abort_i = 0;
         expect_abort("R8 core event", 6'b000100 << ((k < 2) ? 0 : k - 1), 16'h0600 + 16'(k));
      end
   endtask

   task automatic t_start_ignored();
      begin_tx(16'h0700);
      start_i = 1; fail_pc_i = 16'h0777; step(); start_i = 0;
      abort_i = 1; step(); abort_i = 0;
      expect_abort("R2 restart ignored", 6'b100000, 16'h0700);
      begin_tx(16'h0710);
      store(16'h0080, 32'h8080);
      store(16'h0090, 32'h9090);
      exp_line[0] = 16'h0080; exp_data[0] = 32'h8080;
      exp_line[1] = 16'h0090; exp_data[1] = 32'h9090;
      commit_drain(2, 1);
   endtask

   task automatic t_priority();
      begin_tx(16'h0800);
      store(16'h00a0, 32'haaaa);
      commit_i = 1; evt_tlb_i = 1; step(); commit_i = 0; evt_tlb_i = 0;
      expect_abort("R11 abort beats commit", 6'b001000, 16'h0800);
      chk("R11 no write later", mem_wr_o, 0);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      t_reset();
      t_commit_basic();
      t_commit_empty();
      t_conflict_read();
      t_conflict_write();
      t_capacity_write();
      t_capacity_read();
      t_events();
      t_start_ignored();
      t_priority();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end
endmodule